// File: doc/BRIEF.md
# Min/Max Unit with Win Detection

This block takes two XLEN-bit operands and returns either the smaller or the larger one. The comparison is either two's-complement or plain magnitude, as the op code selects. It also reports through an overflow flag whether the second operand was the one picked. A caller that passes a fixed limit as the second operand gets a clamp and learns in the same operation whether the clamp acted. To detect the opposite case, the caller swaps the two operands; no second operation is needed.

When record mode is requested, the block also produces a three-bit condition field. The field comes from comparing operand A with operand B, never from comparing the result with zero. A sticky summary bit gathers overflow across a run of operations, so a clamp anywhere in a batch can be seen once the batch is done. All results are registered and appear one cycle after the input strobe.

Top module: `mmx_unit`

## Requirements
- R1: The op code `op_i` selects the operation: bit 0 = 1 picks the larger operand, bit 0 = 0 picks the smaller; the result appears on `res_o`.
- R2: With `op_i` bit 1 = 1 the operands are ordered as two's-complement signed numbers; with bit 1 = 0 they are ordered as unsigned magnitudes.
- R3: `ov_o` is 1 exactly when operand B is strictly the selected operand: B > A for a max operation, or B < A for a min operation.
- R4: When A equals B, `ov_o` is 0 and `res_o` equals A.
- R5: For an operation with `rec_i` = 1, `cond_o` = {lt, gt, eq} (bit 2 = A<B, bit 1 = A>B, bit 0 = A==B), using the ordering chosen by `op_i` bit 1. Exactly one bit is set, and `cond_vld_o` is 1 in the same cycle as `valid_o`.
- R6: For an operation with `rec_i` = 0, `cond_vld_o` stays 0 and `cond_o` keeps its previous value.
- R7: `sum_ov_o` goes to 1 in the cycle when an overflowing result is presented. It then stays at 1 until it is cleared.
- R8: `sum_clr_i` clears `sum_ov_o` synchronously; it takes effect on the next cycle. If the clear arrives in the same cycle as an accepted operation that overflows, `sum_ov_o` is set.
- R9: `valid_o`, `res_o`, `ov_o` and the condition outputs are registered. They appear exactly one clock after the cycle in which `valid_i` is 1. `res_o` and `ov_o` hold their values between operations.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Bit 0: 1 = max, 0 = min; bit 1: 1 = signed, 0 = unsigned |
| rec_i | input | 1 | Record mode: produce a condition field |
| a_i | input | XLEN | Operand A |
| b_i | input | XLEN | Operand B, the candidate whose win is flagged |
| sum_clr_i | input | 1 | Synchronous clear of the sticky summary bit |
| valid_o | output | 1 | Result strobe |
| res_o | output | XLEN | Selected operand |
| ov_o | output | 1 | Operand B won |
| cond_o | output | 3 | {lt, gt, eq} from comparing A with B |
| cond_vld_o | output | 1 | Condition field updated this cycle |
| sum_ov_o | output | 1 | Sticky summary overflow |

## Verification
Each result, each flag and the condition field is due exactly one clock after the strobe cycle. The sticky bit moves on that same edge, whether the change comes from a set or from a clear. The driver applies one input set per cycle on the falling edge and queues what it expects after the next rising edge. The monitor samples shortly after each rising edge and compares against the oldest queued item, so every comparison lands in the cycle in which the value is due. Idle cycles and clear-only cycles are queued as well, which lets the bench check the held condition field and the sticky bit in the cycles with no operation.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
  typedef enum logic [1:0] {
    OP_UMIN = 2'b00,
    OP_UMAX = 2'b01,
    OP_SMIN = 2'b10,
    OP_SMAX = 2'b11
  } mm_op_e;

  localparam int unsigned OP_MAX_BIT = 0;
  localparam int unsigned OP_SGN_BIT = 1;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cond_t;
endpackage

// File: rtl/mmx_cmp.sv
module mmx_cmp #(
  parameter int unsigned W         = 64,
  parameter bit          BIAS_SIGN = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  output mmx_pkg::cond_t cmp_o
);
  localparam int unsigned MSB = W - 1;

  logic a_lt_b;
  logic a_gt_b;

  generate
    if (BIAS_SIGN) begin : g_bias
      // flip sign bits so one magnitude comparator serves both orderings
      logic [W-1:0] a_k, b_k;
      always_comb begin
        a_k      = a_i;
        b_k      = b_i;
        a_k[MSB] = a_i[MSB] ^ sgn_i;
        b_k[MSB] = b_i[MSB] ^ sgn_i;
        a_lt_b   = a_k < b_k;
        a_gt_b   = a_k > b_k;
      end
    end else begin : g_dual
      always_comb begin
        if (sgn_i) begin
          a_lt_b = $signed(a_i) < $signed(b_i);
          a_gt_b = $signed(a_i) > $signed(b_i);
        end else begin
          a_lt_b = a_i < b_i;
          a_gt_b = a_i > b_i;
        end
      end
    end
  endgenerate

  always_comb begin
    cmp_o.lt = a_lt_b;
    cmp_o.gt = a_gt_b;
    cmp_o.eq = ~(a_lt_b | a_gt_b);
  end
endmodule

// File: rtl/mmx_sel.sv
module mmx_sel #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           max_i,
  input  mmx_pkg::cond_t cmp_i,
  output logic [W-1:0]   res_o,
  output logic           b_win_o
);
  always_comb begin
    // B wins only on strict ordering; a tie keeps A
    b_win_o = max_i ? cmp_i.lt : cmp_i.gt;
    res_o   = b_win_o ? b_i : a_i;
  end
endmodule

// File: rtl/mmx_out_reg.sv
module mmx_out_reg #(
  parameter int unsigned W = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic           rec_i,
  input  logic [W-1:0]   res_i,
  input  logic           ov_i,
  input  mmx_pkg::cond_t cond_i,
  input  logic           sum_clr_i,
  output logic           valid_o,
  output logic [W-1:0]   res_o,
  output logic           ov_o,
  output logic [2:0]     cond_o,
  output logic           cond_vld_o,
  output logic           sum_ov_o
);
  logic           valid_q;
  logic [W-1:0]   res_q;
  logic           ov_q;
  mmx_pkg::cond_t cond_q;
  logic           cond_vld_q;
  logic           sum_q;
  logic           ov_acc;

  assign ov_acc = valid_i & ov_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      res_q      <= '0;
      ov_q       <= 1'b0;
      cond_q     <= '0;
      cond_vld_q <= 1'b0;
      sum_q      <= 1'b0;
    end else begin
      valid_q    <= valid_i;
      cond_vld_q <= valid_i & rec_i;
      if (valid_i) begin
        res_q <= res_i;
        ov_q  <= ov_i;
        if (rec_i) cond_q <= cond_i;
      end
      // set wins over clear
      sum_q <= (sum_q & ~sum_clr_i) | ov_acc;
    end
  end

  assign valid_o    = valid_q;
  assign res_o      = res_q;
  assign ov_o       = ov_q;
  assign cond_o     = cond_q;
  assign cond_vld_o = cond_vld_q;
  assign sum_ov_o   = sum_q;

  p_cond_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_vld_o |-> ($countones(cond_o) == 1));
  p_cond_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_vld_o |-> $stable(cond_o));
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cond_vld_o && cond_o[0]) |-> !ov_o);
  p_ov_not_eq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cond_vld_o && ov_o) |-> !cond_o[0]);
  p_sum_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ov_o) |-> sum_ov_o);
  p_sum_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_ov_o && !sum_clr_i) |=> sum_ov_o);
  p_sum_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_clr_i && !(valid_i && ov_i)) |=> !sum_ov_o);
  p_cond_vld_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_vld_o |-> valid_o);
endmodule

// File: rtl/mmx_unit.sv
module mmx_unit #(
  parameter int unsigned XLEN      = 64,
  parameter bit          BIAS_SIGN = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic            rec_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sum_clr_i,
  output logic            valid_o,
  output logic [XLEN-1:0] res_o,
  output logic            ov_o,
  output logic [2:0]      cond_o,
  output logic            cond_vld_o,
  output logic            sum_ov_o
);
  import mmx_pkg::*;

  cond_t           cmp;
  logic [XLEN-1:0] sel_res;
  logic            b_win;

  mmx_cmp #(.W(XLEN), .BIAS_SIGN(BIAS_SIGN)) i_cmp (
    .a_i   (a_i),
    .b_i   (b_i),
    .sgn_i (op_i[OP_SGN_BIT]),
    .cmp_o (cmp)
  );

  mmx_sel #(.W(XLEN)) i_sel (
    .a_i     (a_i),
    .b_i     (b_i),
    .max_i   (op_i[OP_MAX_BIT]),
    .cmp_i   (cmp),
    .res_o   (sel_res),
    .b_win_o (b_win)
  );

  mmx_out_reg #(.W(XLEN)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .rec_i      (rec_i),
    .res_i      (sel_res),
    .ov_i       (b_win),
    .cond_i     (cmp),
    .sum_clr_i  (sum_clr_i),
    .valid_o    (valid_o),
    .res_o      (res_o),
    .ov_o       (ov_o),
    .cond_o     (cond_o),
    .cond_vld_o (cond_vld_o),
    .sum_ov_o   (sum_ov_o)
  );

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !cond_vld_o));
  p_res_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(ov_o)));
endmodule

// File: tb/test_mmx_unit.sv
module test_mmx_unit;
  localparam int unsigned XLEN = 64;
  localparam logic [XLEN-1:0] SMIN_V = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] SMAX_V = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] ONES_V = '1;

  typedef struct {
    logic            vld;
    logic [XLEN-1:0] res;
    logic            ov;
    logic [2:0]      cond;
    logic            cvld;
    logic            sum;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [1:0]      op = 2'b00;
  logic            rec = 1'b0;
  logic [XLEN-1:0] a = '0;
  logic [XLEN-1:0] b = '0;
  logic            clr = 1'b0;
  logic            valid_o, ov_o, cvld_o, sum_o;
  logic [XLEN-1:0] res_o;
  logic [2:0]      cond_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [2:0] last_cond = 3'b000;
  logic       m_sum = 1'b0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  mmx_unit #(.XLEN(XLEN)) i_mmx_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .rec_i(rec),
    .a_i(a), .b_i(b), .sum_clr_i(clr), .valid_o(valid_o), .res_o(res_o),
    .ov_o(ov_o), .cond_o(cond_o), .cond_vld_o(cvld_o), .sum_ov_o(sum_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; expected outputs after the next rising edge are queued
  task automatic step(input logic v, input logic [1:0] o, input logic r,
                      input logic [XLEN-1:0] x, input logic [XLEN-1:0] y,
                      input logic c, input string tag);
    exp_t e;
    logic lt, gt, bw;
    @(negedge clk);
    valid = v; op = o; rec = r; a = x; b = y; clr = c;
    if (o[1]) begin
      lt = $signed(x) < $signed(y);
      gt = $signed(x) > $signed(y);
    end else begin
      lt = x < y;
      gt = x > y;
    end
    bw = o[0] ? lt : gt;
    e.vld  = v;
    e.res  = bw ? y : x;
    e.ov   = bw;
    e.cvld = v & r;
    if (v && r) last_cond = {lt, gt, !(lt || gt)};
    e.cond = last_cond;
    m_sum  = (m_sum && !c) || (v && bw);
    e.sum  = m_sum;
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R9", "valid_o", XLEN'(valid_o), XLEN'(e.vld));
        chk(e.tag, "sum_ov_o", XLEN'(sum_o), XLEN'(e.sum));
        chk(e.vld && !e.cvld ? "R6" : "R5", "cond_o", XLEN'(cond_o), XLEN'(e.cond));
        chk(e.cvld ? "R5" : "R6", "cond_vld_o", XLEN'(cvld_o), XLEN'(e.cvld));
        if (e.vld) begin
          chk(e.tag, "res_o", res_o, e.res);
          chk("R3", "ov_o", XLEN'(ov_o), XLEN'(e.ov));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [XLEN-1:0] ra, rb;
    repeat (2) @(negedge clk);
    // R10: reset state
    chk("R10", "valid_o", XLEN'(valid_o), '0);
    chk("R10", "res_o", res_o, '0);
    chk("R10", "ov_o", XLEN'(ov_o), '0);
    chk("R10", "cond_o", XLEN'(cond_o), '0);
    chk("R10", "cond_vld_o", XLEN'(cvld_o), '0);
    chk("R10", "sum_ov_o", XLEN'(sum_o), '0);
    rst_n = 1'b1;

    // R1: all four variants, B larger in both orderings
    step(1, 2'b01, 1, 64'd5, 64'd9, 0, "R1");
    step(1, 2'b00, 1, 64'd5, 64'd9, 0, "R1");
    step(1, 2'b11, 1, 64'd5, 64'd9, 0, "R1");
    step(1, 2'b10, 1, 64'd5, 64'd9, 0, "R1");
    // R2: signed and unsigned orderings disagree on extremes
    step(1, 2'b11, 1, SMIN_V, SMAX_V, 0, "R2");
    step(1, 2'b01, 1, SMIN_V, SMAX_V, 0, "R2");
    step(1, 2'b10, 1, ONES_V, 64'd0, 0, "R2");
    step(1, 2'b00, 1, ONES_V, 64'd0, 0, "R2");
    step(1, 2'b11, 0, ONES_V, SMIN_V, 0, "R2");
    step(1, 2'b00, 0, SMAX_V, ONES_V, 0, "R2");
    // R4: equal operands, no winner
    step(1, 2'b11, 1, SMIN_V, SMIN_V, 0, "R4");
    step(1, 2'b00, 1, ONES_V, ONES_V, 0, "R4");
    // R6: rec off keeps the last condition
    step(1, 2'b01, 0, 64'd1, 64'd2, 0, "R6");
    step(0, 2'b01, 1, 64'd3, 64'd2, 0, "R6");
    // R8: clear alone, then clear with a coincident overflow, then clear with no overflow
    step(0, 2'b00, 0, 64'd0, 64'd0, 1, "R8");
    step(1, 2'b01, 1, 64'd2, 64'd7, 1, "R8");
    step(1, 2'b01, 1, 64'd9, 64'd7, 1, "R8");
    // R7: batch of clamps with no win, then one win, then no wins stay sticky
    step(1, 2'b11, 1, 64'd50, 64'd10, 0, "R7");
    step(1, 2'b11, 1, 64'd60, 64'd10, 0, "R7");
    step(1, 2'b11, 1, 64'd3, 64'd10, 0, "R7");
    step(1, 2'b11, 1, 64'd70, 64'd10, 0, "R7");
    step(0, 2'b11, 0, 64'd0, 64'd0, 0, "R7");
    // R3: swapped operands for the opposite detection
    step(1, 2'b10, 1, 64'd10, 64'd3, 1, "R3");
    step(1, 2'b10, 1, 64'd3, 64'd10, 0, "R3");
    // R1: mixed random traffic, with occasional idles and clears
    for (int i = 0; i < 300; i++) begin
      ra = {$urandom, $urandom};
      rb = (i % 7 == 0) ? ra : {$urandom, $urandom};
      if (i % 5 == 0) rb[XLEN-1] = ~ra[XLEN-1];
      step(($urandom % 6) != 0, 2'($urandom), 1'($urandom), ra, rb,
           ($urandom % 9) == 0, "R1");
    end
    step(0, 2'b00, 0, 64'd0, 64'd0, 0, "R7");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule